// File: doc/BRIEF.md
# One-Time-Programmable Memory Access Gate

This block sits between a one-time-programmable code store and its three requesters: a programming port that writes and verifies bytes, the CPU instruction fetch path, and the CPU data-read path. Each request is a single-cycle strobe with a kind, a 16-bit address and, for writes, a data byte. One cycle later the block returns either a data byte or an error pulse. It makes this decision from the address region and from the two lock bits held in the upper bits of a configuration byte.

The storage is modelled inside the block. It holds a main code array, a 32-byte customer area, three fixed identification bytes and two configuration bytes. Every stored bit starts at 1, and programming can only clear bits. The two lock bits form an ordered, one-way ladder. The first bit freezes all programming except the step that sets the second bit. The second bit also shuts off verify. The CPU read paths never depend on the lock state, but the customer area may be read as data and never fetched as code.

Top module: `otp_guard`

## Requirements
- R1: A response (`rsp_valid` high for one cycle) follows exactly one cycle after each request cycle and at no other time. After reset `rsp_valid` and `rsp_err` are low.
- R2: An accepted program request (`req_kind` 2'b00) stores the bitwise AND of the old byte and `req_wdata`, so no bit returns from 0 to 1. The response data is the resulting byte.
- R3: While bit 7 and bit 6 of the byte at FD01h are both 1, programming and verify (`req_kind` 2'b01) are accepted in the code array, the customer area and both configuration bytes. A verify returns the stored byte.
- R4: While bit 6 of FD01h is 0 and bit 7 is 1, every program request is refused except a write to FD01h with data exactly 7Fh. Verify stays accepted.
- R5: While bits 7 and 6 of FD01h are both 0, every program and every verify request is refused.
- R6: A program request to FD01h whose data has bit 7 at 0 is refused while bit 6 of FD01h is still 1. The combination of bit 7 at 0 with bit 6 at 1 can never be reached.
- R7: Data reads (`req_kind` 2'b11) in FCE0h–FCFFh return the customer bytes. Instruction fetches (`req_kind` 2'b10) in that range are refused.
- R8: The identification bytes at FC30h, FC31h and FC60h read as 5Ah, C3h and 21h with the default parameters, and programming them is refused. The configuration bytes are read at FD00h and FD01h.
- R9: The code array spans 0000h–0FFFh with the default parameters. Every address outside the defined regions is refused for all request kinds.
- R10: A refused request gives `rsp_err` high for one cycle with `rsp_data` at FFh and leaves every stored byte unchanged.
- R11: Fetches and data reads of defined regions other than the customer area are accepted whatever the lock state.
- R12: After reset every programmable byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | 00 program, 01 verify, 10 fetch, 11 data read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Program data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 8 | Returned byte, FFh on refusal |
| rsp_err | output | 1 | Refusal pulse |

## Verification
The assertions assume that the request fields are stable and known during any cycle in which `req_valid` is high. They also assume that reset is applied before the first request, so the lock bits start from the erased state. The bench drives only fully defined request fields on the falling edge and leaves an idle cycle between requests. In the unlocked random phase it forces bits 7 and 6 of any random FD01h write to 1, so that the lock ladder is climbed only by the directed steps and each lock level receives its own share of random traffic.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

  typedef enum logic [1:0] {
    KIND_PROG   = 2'b00,
    KIND_VERIFY = 2'b01,
    KIND_FETCH  = 2'b10,
    KIND_READ   = 2'b11
  } req_kind_e;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_CODE,
    RGN_CUST,
    RGN_ID0,
    RGN_ID1,
    RGN_ID2,
    RGN_CFGA,
    RGN_CFGB
  } region_e;

  localparam logic [15:0] ADDR_ID0  = 16'hFC30;
  localparam logic [15:0] ADDR_ID1  = 16'hFC31;
  localparam logic [15:0] ADDR_ID2  = 16'hFC60;
  localparam logic [15:0] ADDR_CFGA = 16'hFD00;
  localparam logic [15:0] ADDR_CFGB = 16'hFD01;
  localparam logic [10:0] CUST_PAGE = 11'h7E7;

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
  import otp_guard_pkg::*;
#(
  parameter int CODE_AW = 12
) (
  input  logic [15:0]        addr,
  output region_e            region,
  output logic [CODE_AW-1:0] code_idx,
  output logic [4:0]         cust_idx
);

  localparam int HI_W = 16 - CODE_AW;

  logic [HI_W-1:0] upper;

  assign upper    = addr[15:CODE_AW];
  assign code_idx = addr[CODE_AW-1:0];
  assign cust_idx = addr[4:0];

  always_comb begin
    region = RGN_NONE;
    if (upper == '0)                     region = RGN_CODE;
    else if (addr[15:5] == CUST_PAGE)    region = RGN_CUST;
    else if (addr == ADDR_ID0)           region = RGN_ID0;
    else if (addr == ADDR_ID1)           region = RGN_ID1;
    else if (addr == ADDR_ID2)           region = RGN_ID2;
    else if (addr == ADDR_CFGA)          region = RGN_CFGA;
    else if (addr == ADDR_CFGB)          region = RGN_CFGB;
  end

endmodule

// File: rtl/otp_policy.sv
module otp_policy
  import otp_guard_pkg::*;
(
  input  req_kind_e   kind,
  input  region_e     region,
  input  logic [1:0]  lock_bits,
  input  logic [7:0]  wdata,
  output logic        allow
);

  logic first_open;
  logic second_open;
  logic writable;

  assign first_open  = lock_bits[0];
  assign second_open = lock_bits[1];
  assign writable    = (region == RGN_CODE) || (region == RGN_CUST) ||
                       (region == RGN_CFGA) || (region == RGN_CFGB);

  always_comb begin
    allow = 1'b0;
    if (region != RGN_NONE) begin
      unique case (kind)
        KIND_PROG: begin
          if (first_open) begin
            allow = writable && !((region == RGN_CFGB) && !wdata[7]);
          end else if (second_open) begin
            allow = (region == RGN_CFGB) && (wdata == 8'h7F);
          end
        end
        KIND_VERIFY: allow = first_open || second_open;
        KIND_FETCH:  allow = (region != RGN_CUST);
        KIND_READ:   allow = 1'b1;
        default:     allow = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_guard_pkg::*;
#(
  parameter int         CODE_AW = 12,
  parameter logic [7:0] ID_B0   = 8'h5A,
  parameter logic [7:0] ID_B1   = 8'hC3,
  parameter logic [7:0] ID_B2   = 8'h21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  region_e            region,
  input  logic [CODE_AW-1:0] code_idx,
  input  logic [4:0]         cust_idx,
  input  logic [7:0]         wdata,
  output logic [7:0]         rd_data,
  output logic [1:0]         lock_bits
);

  localparam int CODE_DEPTH = 1 << CODE_AW;
  localparam int CUST_DEPTH = 32;

  logic [7:0] code_q [CODE_DEPTH];
  logic [7:0] cust_q [CUST_DEPTH];
  logic [7:0] cfga_q;
  logic [7:0] cfgb_q;

  always_comb begin
    unique case (region)
      RGN_CODE: rd_data = code_q[code_idx];
      RGN_CUST: rd_data = cust_q[cust_idx];
      RGN_ID0:  rd_data = ID_B0;
      RGN_ID1:  rd_data = ID_B1;
      RGN_ID2:  rd_data = ID_B2;
      RGN_CFGA: rd_data = cfga_q;
      RGN_CFGB: rd_data = cfgb_q;
      default:  rd_data = 8'hFF;
    endcase
  end

  assign lock_bits = {cfgb_q[7], cfgb_q[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CODE_DEPTH; i++) code_q[i] <= 8'hFF;
    end else if (wr_en && (region == RGN_CODE)) begin
      code_q[code_idx] <= code_q[code_idx] & wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CUST_DEPTH; i++) cust_q[i] <= 8'hFF;
    end else if (wr_en && (region == RGN_CUST)) begin
      cust_q[cust_idx] <= cust_q[cust_idx] & wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfga_q <= 8'hFF;
      cfgb_q <= 8'hFF;
    end else begin
      if (wr_en && (region == RGN_CFGA)) cfga_q <= cfga_q & wdata;
      if (wr_en && (region == RGN_CFGB)) cfgb_q <= cfgb_q & wdata;
    end
  end

endmodule

// File: rtl/otp_guard.sv
module otp_guard
  import otp_guard_pkg::*;
#(
  parameter int         CODE_AW = 12,
  parameter logic [7:0] ID_B0   = 8'h5A,
  parameter logic [7:0] ID_B1   = 8'hC3,
  parameter logic [7:0] ID_B2   = 8'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        rsp_err
);

  region_e            region;
  logic [CODE_AW-1:0] code_idx;
  logic [4:0]         cust_idx;
  logic [7:0]         rd_data;
  logic [1:0]         lock_bits;
  logic               allow;
  logic               wr_en;
  req_kind_e          kind;

  logic       valid_d, err_d;
  logic [7:0] data_d;
  logic       valid_q, err_q;
  logic [7:0] data_q;

  assign kind = req_kind_e'(req_kind);

  otp_addr_decode #(.CODE_AW(CODE_AW)) decode_i (
    .addr     (req_addr),
    .region   (region),
    .code_idx (code_idx),
    .cust_idx (cust_idx)
  );

  otp_policy policy_i (
    .kind      (kind),
    .region    (region),
    .lock_bits (lock_bits),
    .wdata     (req_wdata),
    .allow     (allow)
  );

  assign wr_en = req_valid && (kind == KIND_PROG) && allow;

  otp_store #(
    .CODE_AW (CODE_AW),
    .ID_B0   (ID_B0),
    .ID_B1   (ID_B1),
    .ID_B2   (ID_B2)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .region    (region),
    .code_idx  (code_idx),
    .cust_idx  (cust_idx),
    .wdata     (req_wdata),
    .rd_data   (rd_data),
    .lock_bits (lock_bits)
  );

  always_comb begin
    valid_d = req_valid;
    err_d   = req_valid && !allow;
    data_d  = 8'hFF;
    if (req_valid && allow) begin
      data_d = (kind == KIND_PROG) ? (rd_data & req_wdata) : rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= 8'hFF;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      data_q  <= data_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/otp_guard_chk.sv
module otp_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_kind,
  input logic [15:0] req_addr,
  input logic        rsp_valid,
  input logic [7:0]  rsp_data,
  input logic        rsp_err,
  input logic [1:0]  sec_bits
);

  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R10
  err_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && (rsp_data == 8'hFF)));

  // R2
  first_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_bits[0] |=> !sec_bits[0]);

  // R2
  second_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_bits[1] |=> !sec_bits[1]);

  // R6
  no_bad_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sec_bits[1] && sec_bits[0]));

  // R7
  cust_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 2'b10) && (req_addr[15:5] == 11'h7E7)) |=> rsp_err);

  // R5
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind[1] && (sec_bits == 2'b00)) |=> rsp_err);

  // R9
  undef_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr >= 16'hFE00)) |=> rsp_err);

endmodule

bind otp_guard otp_guard_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err),
  .sec_bits  (lock_bits)
);

// File: tb/otp_guard_tb_top.sv
module otp_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_code [4096];
  logic [7:0] m_cust [32];
  logic [7:0] m_cfga;
  logic [7:0] m_cfgb;

  otp_guard dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // region codes: 0 none, 1 code, 2 cust, 3..5 id, 6 cfga, 7 cfgb
  function automatic int m_region(logic [15:0] a);
    if (a < 16'h1000)            return 1;
    if (a[15:5] == 11'h7E7)      return 2;
    if (a == 16'hFC30)           return 3;
    if (a == 16'hFC31)           return 4;
    if (a == 16'hFC60)           return 5;
    if (a == 16'hFD00)           return 6;
    if (a == 16'hFD01)           return 7;
    return 0;
  endfunction

  function automatic logic [7:0] m_peek(logic [15:0] a);
    case (m_region(a))
      1: return m_code[a[11:0]];
      2: return m_cust[a[4:0]];
      3: return 8'h5A;
      4: return 8'hC3;
      5: return 8'h21;
      6: return m_cfga;
      7: return m_cfgb;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic m_apply(logic [1:0] k, logic [15:0] a, logic [7:0] wd,
                         output logic [7:0] ed, output logic ee);
    int r;
    logic ok;
    logic sb1, sb2;
    r   = m_region(a);
    sb1 = m_cfgb[6];
    sb2 = m_cfgb[7];
    ok  = 1'b0;
    if (r != 0) begin
      case (k)
        2'b00: begin
          if (sb1) ok = (r == 1 || r == 2 || r == 6 || r == 7) && !(r == 7 && !wd[7]);
          else if (sb2) ok = (r == 7) && (wd == 8'h7F);
        end
        2'b01: ok = sb1 || sb2;
        2'b10: ok = (r != 2);
        default: ok = 1'b1;
      endcase
    end
    ee = !ok;
    ed = 8'hFF;
    if (ok) begin
      if (k == 2'b00) begin
        ed = m_peek(a) & wd;
        case (r)
          1: m_code[a[11:0]] = ed;
          2: m_cust[a[4:0]]  = ed;
          6: m_cfga = ed;
          7: m_cfgb = ed;
          default: ;
        endcase
      end else begin
        ed = m_peek(a);
      end
    end
  endtask

  task automatic do_req(string tag, logic [1:0] k, logic [15:0] a, logic [7:0] wd);
    logic [7:0] ed;
    logic ee;
    @(negedge clk);
    check("R1", {15'd0, rsp_valid}, 16'd0, "idle rsp_valid");
    m_apply(k, a, wd, ed, ee);
    req_valid = 1'b1;
    req_kind  = k;
    req_addr  = a;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", {15'd0, rsp_valid}, 16'd1, "rsp_valid");
    check(tag, {8'd0, rsp_data}, {8'd0, ed}, $sformatf("data k=%0d a=%h", k, a));
    check(tag, {15'd0, rsp_err}, {15'd0, ee}, $sformatf("err k=%0d a=%h", k, a));
  endtask

  function automatic logic [15:0] rnd_addr();
    case ($urandom_range(0, 9))
      0, 1, 2: return 16'($urandom_range(0, 63));
      3:       return 16'($urandom_range(0, 4095));
      4:       return 16'hFCE0 + 16'($urandom_range(0, 31));
      5:       return ($urandom_range(0, 1) == 0) ? 16'hFC30 : 16'hFC60;
      6:       return 16'hFD00;
      7:       return 16'hFD01;
      8:       return 16'h1000 + 16'($urandom_range(0, 16'hEAFF));
      default: return 16'hFE00 + 16'($urandom_range(0, 255));
    endcase
  endfunction

  function automatic string kind_tag(logic [1:0] k);
    case (k)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic rnd_phase(int n, bit protect_lock);
    for (int i = 0; i < n; i++) begin
      logic [1:0]  k;
      logic [15:0] a;
      logic [7:0]  wd;
      k  = 2'($urandom_range(0, 3));
      a  = rnd_addr();
      wd = 8'($urandom);
      if (protect_lock && a == 16'hFD01) wd = wd | 8'hC0;
      do_req(kind_tag(k), k, a, wd);
    end
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < 4096; i++) m_code[i] = 8'hFF;
    for (int i = 0; i < 32; i++) m_cust[i] = 8'hFF;
    m_cfga = 8'hFF;
    m_cfgb = 8'hFF;
    req_valid = 1'b0;
    req_kind  = 2'b00;
    req_addr  = 16'h0000;
    req_wdata = 8'h00;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {15'd0, rsp_valid}, 16'd0, "reset rsp_valid");
    check("R1", {15'd0, rsp_err}, 16'd0, "reset rsp_err");
    rst_n = 1'b1;

    // R12 erased contents
    do_req("R12", 2'b11, 16'h0000, 8'h00);
    do_req("R12", 2'b11, 16'hFD01, 8'h00);
    do_req("R12", 2'b11, 16'hFCFF, 8'h00);
    // R2 AND accumulation
    do_req("R2", 2'b00, 16'h0010, 8'hA5);
    do_req("R2", 2'b00, 16'h0010, 8'h0F);
    do_req("R2", 2'b00, 16'h0010, 8'hFF);
    do_req("R2", 2'b11, 16'h0010, 8'h00);
    // R3 verify open
    do_req("R3", 2'b01, 16'h0010, 8'h00);
    do_req("R3", 2'b00, 16'hFD00, 8'h3C);
    do_req("R3", 2'b01, 16'hFD00, 8'h00);
    // R7 customer area
    do_req("R7", 2'b00, 16'hFCE5, 8'h3C);
    do_req("R7", 2'b11, 16'hFCE5, 8'h00);
    do_req("R7", 2'b10, 16'hFCE5, 8'h00);
    do_req("R7", 2'b10, 16'hFCE0, 8'h00);
    // R8 identification bytes
    do_req("R8", 2'b11, 16'hFC30, 8'h00);
    do_req("R8", 2'b10, 16'hFC31, 8'h00);
    do_req("R8", 2'b11, 16'hFC60, 8'h00);
    do_req("R8", 2'b00, 16'hFC30, 8'h00);
    do_req("R8", 2'b11, 16'hFC30, 8'h00);
    // R9 undefined addresses and code edge
    do_req("R9", 2'b11, 16'h1000, 8'h00);
    do_req("R9", 2'b11, 16'h0FFF, 8'h00);
    do_req("R9", 2'b00, 16'hFD02, 8'h00);
    do_req("R9", 2'b10, 16'hFC32, 8'h00);
    // R6 second bit before first is refused
    do_req("R6", 2'b00, 16'hFD01, 8'h7F);
    do_req("R6", 2'b11, 16'hFD01, 8'h00);
    // R11 fetch open
    do_req("R11", 2'b10, 16'h0010, 8'h00);

    rnd_phase(500, 1'b1);

    // R4 first lock level
    do_req("R4", 2'b00, 16'hFD01, 8'hBF);
    do_req("R4", 2'b00, 16'h0020, 8'h00);
    do_req("R10", 2'b11, 16'h0020, 8'h00);
    do_req("R4", 2'b00, 16'hFD01, 8'h3F);
    do_req("R4", 2'b00, 16'hFCE1, 8'h00);
    do_req("R4", 2'b01, 16'h0010, 8'h00);
    rnd_phase(300, 1'b0);
    do_req("R4", 2'b00, 16'hFD01, 8'h7F);

    // R5 full lock
    do_req("R5", 2'b01, 16'h0010, 8'h00);
    do_req("R5", 2'b00, 16'h0030, 8'h00);
    do_req("R5", 2'b00, 16'hFD01, 8'h00);
    do_req("R11", 2'b10, 16'h0010, 8'h00);
    do_req("R11", 2'b11, 16'hFD01, 8'h00);
    do_req("R7", 2'b11, 16'hFCE5, 8'h00);
    rnd_phase(300, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule